// File: doc/BRIEF.md
# Initialization Record Sequencer

The sequencer runs a list of initialization records held in a record ROM. Each record becomes zero or more transactions on a simple register bus toward a target device. Software or a boot controller supplies a first index and an end index (exclusive) and pulses a start input. The block then fetches each record in that window in ascending order. It folds opcodes that are specific to a chip variant or a platform onto a small generic set, and executes the result. Records meant for another variant or platform are dropped without touching the bus.

The generic operations are single reads (returned data discarded), single writes, word-string copies sourced from a data ROM, zero fills and repeated 64-bit pattern writes. Mailbox, bulk and compressed copies are executed as plain string copies. A compressed copy also raises a one-cycle flag so that the surrounding logic can record that decompression was not applied. The chip variant and the platform are static configuration inputs.

Top module: `init_seq`

## Requirements
- R1: Record layout: `rec_data_i` = {word1, word0}. word0[7:0] is the opcode and word0[31:8] is the 24-bit target byte address. word1 is the write value, or holds data offset in [15:0] and data length in [31:16] for copies and pattern fills.
- R2: With `variant_i`=0, opcodes 0x0A..0x12 execute as opcode minus 9. With `variant_i`=1 they cause no bus access.
- R3: With `variant_i`=1, opcodes 0x13..0x1B execute as opcode minus 0x12. With `variant_i`=0 they cause no bus access.
- R4: `platform_i` encodes 0 = ASIC, 1 = FPGA, 2 = emulation. Opcodes 0x1F, 0x1E and 0x1D each perform a single write of word1 only on the matching platform, and nothing otherwise.
- R5: Opcode 0x1C performs a single write only when `platform_i`=2 and `variant_i`=1.
- R6: Opcode 0, opcodes 0x20..0xFF and any opcode not folded into 1..9 cause no bus access.
- R7: Generic opcode 1 performs exactly one bus read at the record address.
- R8: Generic opcodes 2 and 3 perform one write of word1 at the record address.
- R9: Generic opcodes 4, 5 and 9 write `length` words. Word k comes from data ROM address base+offset+k and goes to bus address addr+4k. The base is `BASE_V0` for variant 0 and `BASE_V1` for variant 1. A length of 0 causes no access.
- R10: Generic opcode 7 behaves as R9 and pulses `unsup_o` once for the record. No other opcode pulses it.
- R11: Generic opcode 6 writes zero to word1[15:0] consecutive word addresses starting at the record address.
- R12: Generic opcode 8 reads a low word at base+offset and a high word at base+offset+1. It writes the pair `length` times: low word at addr+8e and high word at addr+8e+4 for entry e.
- R13: Only records first..end-1 are executed, in order. `done_o` pulses for one cycle, two cycles after the final bus acceptance. An empty window (first >= end) gives done with no access.
- R14: A bus access completes on a clock edge where the strobe and `bus_rdy_i` are both high. Until then the strobe, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | Chip variant select (0 or 1) |
| platform_i | input | 2 | Platform: 0 ASIC, 1 FPGA, 2 emulation |
| start_i | input | 1 | Start pulse, taken when idle |
| first_idx_i | input | REC_AW | First record index |
| end_idx_i | input | REC_AW | Index one past the last record |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| unsup_o | output | 1 | Compressed copy executed without decompression |
| rec_idx_o | output | REC_AW | Record ROM address |
| rec_data_i | input | 64 | Record ROM data, one cycle after address |
| dat_addr_o | output | DAT_AW | Data ROM address |
| dat_rdata_i | input | 32 | Data ROM data, one cycle after address |
| bus_addr_o | output | 24 | Register bus byte address |
| bus_wdata_o | output | 32 | Register bus write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdy_i | input | 1 | Bus ready; completes the current access |

## Verification
Every opcode from 0 to 31 is tried under both variants and all three platforms, one record per run. This separates the fold ranges, the platform-only writes, the special emulation write and the silently skipped codes, and checks that each generic class produces the right count, order, addresses and data. A mixed multi-record window is then run with ready always high and again with ready stalling every third cycle. Matching transaction lists show that back-pressure changes only timing, and the done timing is measured against the last accepted access. Directed cases cover an empty window, a partial window that must leave later records untouched, and a zero-length string.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  localparam int OPC_W = 8;
  localparam int ADR_W = 24;
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {K_SKIP, K_RD, K_WR, K_STR, K_ZERO, K_PAT} kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_DREQ, S_DCAP, S_PLO, S_PHI, S_PCAP, S_BUS, S_NEXT, S_DONE
  } st_e;

  localparam logic [1:0] PF_ASIC = 2'd0;
  localparam logic [1:0] PF_FPGA = 2'd1;
  localparam logic [1:0] PF_EMUL = 2'd2;

  localparam logic [7:0] V0_LO = 8'h0A, V0_HI = 8'h12;
  localparam logic [7:0] V1_LO = 8'h13, V1_HI = 8'h1B;
  localparam logic [7:0] OP_EMUL_V1 = 8'h1C;
  localparam logic [7:0] OP_PF_EMUL = 8'h1D;
  localparam logic [7:0] OP_PF_FPGA = 8'h1E;
  localparam logic [7:0] OP_PF_ASIC = 8'h1F;
  localparam logic [7:0] G_WR = 8'd2;
  localparam logic [7:0] G_ZIP = 8'd7;
endpackage

// File: rtl/init_seq_remap.sv
module init_seq_remap
  import init_seq_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  input  logic             variant_i,
  input  logic [1:0]       platform_i,
  output kind_e            kind_o,
  output logic             comp_o
);
  logic [OPC_W-1:0] gen;
  logic [OPC_W-1:0] pf_op;
  logic             pf_ok;

  always_comb begin
    pf_ok = 1'b1;
    unique case (platform_i)
      PF_ASIC: pf_op = OP_PF_ASIC;
      PF_FPGA: pf_op = OP_PF_FPGA;
      PF_EMUL: pf_op = OP_PF_EMUL;
      default: begin pf_op = '0; pf_ok = 1'b0; end
    endcase
  end

  always_comb begin
    gen = op_i;
    if (op_i >= V0_LO && op_i <= V0_HI) begin
      if (!variant_i) gen = op_i - 8'd9;
    end else if (op_i >= V1_LO && op_i <= V1_HI) begin
      if (variant_i) gen = op_i - 8'h12;
    end else if (pf_ok && op_i == pf_op) begin
      gen = G_WR;
    end else if (op_i == OP_EMUL_V1 && platform_i == PF_EMUL && variant_i) begin
      gen = G_WR;
    end
  end

  always_comb begin
    unique case (gen)
      8'd1:                kind_o = K_RD;
      8'd2, 8'd3:          kind_o = K_WR;
      8'd4, 8'd5, 8'd7,
      8'd9:                kind_o = K_STR;
      8'd6:                kind_o = K_ZERO;
      8'd8:                kind_o = K_PAT;
      default:             kind_o = K_SKIP;
    endcase
  end

  assign comp_o = (gen == G_ZIP);
endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
  import init_seq_pkg::*;
#(
  parameter int REC_AW  = 8,
  parameter int DAT_AW  = 8,
  parameter int BASE_V0 = 0,
  parameter int BASE_V1 = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              start_i,
  input  logic [REC_AW-1:0] first_idx_i,
  input  logic [REC_AW-1:0] end_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unsup_o,
  output logic [REC_AW-1:0] rec_idx_o,
  input  logic [55:0]       rec_body_i,
  input  kind_e             kind_i,
  input  logic              comp_i,
  output logic [DAT_AW-1:0] dat_addr_o,
  input  logic [31:0]       dat_rdata_i,
  output logic [ADR_W-1:0]  bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic              bus_rdy_i
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [DAT_AW-1:0] BASE0 = DAT_AW'(BASE_V0);
  localparam logic [DAT_AW-1:0] BASE1 = DAT_AW'(BASE_V1);

  st_e               st;
  kind_e             kind_q;
  logic [REC_AW-1:0] idx;
  logic [ADR_W-1:0]  addr;
  logic [31:0]       wdata, pat_lo, pat_hi;
  logic [DAT_AW-1:0] dptr;
  logic [CNT_W-1:0]  cnt;
  logic              phase;

  logic [DAT_AW-1:0] dbase;
  logic [LEN_W-1:0]  dlen, zlen;
  logic [REC_AW:0]   idx_nx;

  assign dbase  = variant_i ? BASE1 : BASE0;
  assign dlen   = rec_body_i[40 +: LEN_W];
  assign zlen   = rec_body_i[24 +: LEN_W];
  assign idx_nx = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; kind_q <= K_SKIP; idx <= '0; addr <= '0; wdata <= '0;
      pat_lo <= '0; pat_hi <= '0; dptr <= '0; cnt <= '0; phase <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          idx <= first_idx_i;
          st  <= (first_idx_i < end_idx_i) ? S_FETCH : S_DONE;
        end
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          addr   <= rec_body_i[ADR_W-1:0];
          kind_q <= kind_i;
          phase  <= 1'b0;
          unique case (kind_i)
            K_RD:   begin cnt <= CNT_W'(1); st <= S_BUS; end
            K_WR:   begin cnt <= CNT_W'(1); wdata <= rec_body_i[55:24]; st <= S_BUS; end
            K_STR:  begin
              dptr <= dbase + rec_body_i[24 +: DAT_AW];
              cnt  <= {1'b0, dlen};
              st   <= (dlen == '0) ? S_NEXT : S_DREQ;
            end
            K_ZERO: begin
              wdata <= '0;
              cnt   <= {1'b0, zlen};
              st    <= (zlen == '0) ? S_NEXT : S_BUS;
            end
            K_PAT:  begin
              dptr <= dbase + rec_body_i[24 +: DAT_AW];
              cnt  <= {dlen, 1'b0};
              st   <= (dlen == '0) ? S_NEXT : S_PLO;
            end
            default: st <= S_NEXT;
          endcase
        end
        S_DREQ: st <= S_DCAP;
        S_DCAP: begin wdata <= dat_rdata_i; dptr <= dptr + 1'b1; st <= S_BUS; end
        S_PLO:  st <= S_PHI;
        S_PHI:  begin pat_lo <= dat_rdata_i; st <= S_PCAP; end
        S_PCAP: begin pat_hi <= dat_rdata_i; wdata <= pat_lo; st <= S_BUS; end
        S_BUS: if (bus_rdy_i) begin
          addr <= addr + ADR_W'(4);
          cnt  <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_NEXT;
          else if (kind_q == K_STR) st <= S_DREQ;
          else if (kind_q == K_PAT) begin
            wdata <= phase ? pat_lo : pat_hi;
            phase <= ~phase;
          end
        end
        S_NEXT: begin
          if (idx_nx == {1'b0, end_idx_i}) st <= S_DONE;
          else begin idx <= idx_nx[REC_AW-1:0]; st <= S_FETCH; end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rec_idx_o   = idx;
  assign dat_addr_o  = (st == S_PHI) ? dptr + 1'b1 : dptr;
  assign bus_addr_o  = addr;
  assign bus_wdata_o = wdata;
  assign bus_wr_o    = (st == S_BUS) && (kind_q != K_RD);
  assign bus_rd_o    = (st == S_BUS) && (kind_q == K_RD);
  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_DONE);
  assign unsup_o     = (st == S_DEC) && comp_i;

  AST_HOLD_UNTIL_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) && !bus_rdy_i |=> (bus_wr_o || bus_rd_o) &&
    $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_wr_o)); // R14
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_wr_o && !bus_rd_o); // R13
  AST_SKIP_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_DEC && kind_i == K_SKIP) |=> !bus_wr_o && !bus_rd_o); // R6
  AST_READ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && bus_rdy_i |=> !bus_rd_o); // R7
  AST_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o && kind_q == K_ZERO |-> bus_wdata_o == '0); // R11
endmodule

// File: rtl/init_seq.sv
module init_seq
  import init_seq_pkg::*;
#(
  parameter int REC_AW  = 8,
  parameter int DAT_AW  = 8,
  parameter int BASE_V0 = 0,
  parameter int BASE_V1 = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic [1:0]        platform_i,
  input  logic              start_i,
  input  logic [REC_AW-1:0] first_idx_i,
  input  logic [REC_AW-1:0] end_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unsup_o,
  output logic [REC_AW-1:0] rec_idx_o,
  input  logic [63:0]       rec_data_i,
  output logic [DAT_AW-1:0] dat_addr_o,
  input  logic [31:0]       dat_rdata_i,
  output logic [23:0]       bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic              bus_rdy_i
);
  kind_e kind;
  logic  comp;

  init_seq_remap u_remap (
    .op_i       (rec_data_i[OPC_W-1:0]),
    .variant_i  (variant_i),
    .platform_i (platform_i),
    .kind_o     (kind),
    .comp_o     (comp)
  );

  init_seq_ctrl #(
    .REC_AW (REC_AW), .DAT_AW (DAT_AW), .BASE_V0 (BASE_V0), .BASE_V1 (BASE_V1)
  ) u_ctrl (
    .clk_i, .rst_ni, .variant_i, .start_i, .first_idx_i, .end_idx_i,
    .busy_o, .done_o, .unsup_o, .rec_idx_o,
    .rec_body_i  (rec_data_i[63:8]),
    .kind_i      (kind),
    .comp_i      (comp),
    .dat_addr_o, .dat_rdata_i, .bus_addr_o, .bus_wdata_o,
    .bus_wr_o, .bus_rd_o, .bus_rdy_i
  );

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o)); // R14
  AST_UNSUP_IS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> kind == K_STR); // R10
endmodule

// File: tb/sim_init_seq.sv
module sim_init_seq;
  localparam int REC_AW = 8, DAT_AW = 8, BASE_V0 = 0, BASE_V1 = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic variant = 1'b0, start = 1'b0, rdy = 1'b1;
  logic [1:0] platform = 2'd0;
  logic [REC_AW-1:0] first_idx = '0, end_idx = '0, rec_idx;
  logic busy, done, unsup, bus_wr, bus_rd;
  logic [63:0] rec_q;
  logic [DAT_AW-1:0] dat_addr;
  logic [31:0] dat_q, bus_wdata;
  logic [23:0] bus_addr;

  logic [63:0] rec_mem [0:255];
  logic [31:0] dat_mem [0:255];

  init_seq #(.REC_AW(REC_AW), .DAT_AW(DAT_AW), .BASE_V0(BASE_V0), .BASE_V1(BASE_V1)) u0 (
    .clk_i(clk), .rst_ni, .variant_i(variant), .platform_i(platform), .start_i(start),
    .first_idx_i(first_idx), .end_idx_i(end_idx), .busy_o(busy), .done_o(done),
    .unsup_o(unsup), .rec_idx_o(rec_idx), .rec_data_i(rec_q), .dat_addr_o(dat_addr),
    .dat_rdata_i(dat_q), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_rdy_i(rdy)
  );

  always @(posedge clk) begin
    rec_q <= rec_mem[rec_idx];
    dat_q <= dat_mem[dat_addr];
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_obs = 0, n_exp = 0, n_unsup = 0, last_acc = 0, done_cyc = 0;
  bit done_seen = 0, stall = 0;
  bit        o_rd [0:63];
  bit [23:0] o_a  [0:63];
  bit [31:0] o_d  [0:63];
  bit        e_rd [0:63];
  bit [23:0] e_a  [0:63];
  bit [31:0] e_d  [0:63];

  always @(negedge clk) begin
    cyc++;
    if ((bus_wr || bus_rd) && rdy) begin
      if (n_obs < 64) begin o_rd[n_obs] = bus_rd; o_a[n_obs] = bus_addr; o_d[n_obs] = bus_wdata; end
      n_obs++;
      last_acc = cyc;
    end
    if (unsup) n_unsup++;
    if (done) begin done_seen = 1; done_cyc = cyc; end
  end

  initial forever begin
    @(posedge clk); #1;
    rdy = stall ? ((cyc % 3) != 1) : 1'b1;
  end

  function automatic bit [31:0] dval(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int gen_of(int op, bit v, int pf);
    if (op >= 1 && op <= 9) return op;
    if (op >= 10 && op <= 18) return v ? 0 : op - 9;
    if (op >= 19 && op <= 27) return v ? op - 18 : 0;
    if (op == 28) return (pf == 2 && v) ? 2 : 0;
    if (op == 29) return (pf == 2) ? 2 : 0;
    if (op == 30) return (pf == 1) ? 2 : 0;
    if (op == 31) return (pf == 0) ? 2 : 0;
    return 0;
  endfunction

  task automatic add_exp(bit rd, bit [23:0] a, bit [31:0] d);
    e_rd[n_exp] = rd; e_a[n_exp] = a; e_d[n_exp] = d; n_exp++;
  endtask

  task automatic expect_rec(int op, bit v, int pf, bit [23:0] a, bit [31:0] w1);
    int g = gen_of(op, v, pf);
    int base = v ? BASE_V1 : BASE_V0;
    int off = int'(w1[15:0]);
    int len = int'(w1[31:16]);
    case (g)
      1: add_exp(1, a, 32'h0);
      2, 3: add_exp(0, a, w1);
      4, 5, 7, 9: for (int k = 0; k < len; k++) add_exp(0, a + 24'(4*k), dval(base + off + k));
      6: for (int k = 0; k < off; k++) add_exp(0, a + 24'(4*k), 32'h0);
      8: for (int e = 0; e < len; e++) begin
           add_exp(0, a + 24'(8*e), dval(base + off));
           add_exp(0, a + 24'(8*e + 4), dval(base + off + 1));
         end
      default: ;
    endcase
  endtask

  task automatic run(int f, int e);
    n_obs = 0; n_unsup = 0; done_seen = 0;
    @(posedge clk); #1;
    first_idx = REC_AW'(f); end_idx = REC_AW'(e); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    do @(negedge clk); while (!done_seen);
    #1;
  endtask

  task automatic compare(string req);
    chk(n_obs == n_exp, req, n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs && i < 64; i++) begin
      chk(o_rd[i] == e_rd[i], req, o_rd[i], e_rd[i]);
      chk(o_a[i] == e_a[i], req, o_a[i], e_a[i]);
      if (!e_rd[i]) chk(o_d[i] == e_d[i], req, o_d[i], e_d[i]);
    end
  endtask

  function automatic string tag_of(int op, bit v, int pf);
    int g = gen_of(op, v, pf);
    if (op >= 10 && op <= 18) return "R2";
    if (op >= 19 && op <= 27) return "R3";
    if (op == 28) return "R5";
    if (op >= 29 && op <= 31) return "R4";
    case (g)
      1: return "R7";
      2, 3: return "R8";
      4, 5, 9: return "R9";
      7: return "R10";
      6: return "R11";
      8: return "R12";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #150000000;
    n_fail++;
    $display("FAIL R13 actual=hang expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    bit [31:0] w1;
    for (int i = 0; i < 256; i++) begin dat_mem[i] = dval(i); rec_mem[i] = 64'h0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_wr && !bus_rd, "R13 reset", {busy, done, bus_wr, bus_rd}, 0);
    rst_ni = 1'b1;

    // sweep: every opcode 0..31, both variants, all platforms
    w1 = {16'd2, 16'd3};
    for (int v = 0; v < 2; v++)
      for (int pf = 0; pf < 3; pf++)
        for (int op = 0; op < 32; op++) begin
          variant = v[0]; platform = pf[1:0]; stall = (pf == 1);
          rec_mem[0] = {w1, 24'h000400, 8'(op)};
          n_exp = 0;
          expect_rec(op, v[0], pf, 24'h000400, w1);
          run(0, 1);
          compare(tag_of(op, v[0], pf));
          chk(n_unsup == ((gen_of(op, v[0], pf) == 7) ? 1 : 0), "R10 flag", n_unsup, 0);
        end

    // mixed window, variant 0, ASIC
    variant = 1'b0; platform = 2'd0;
    rec_mem[4] = {32'hCAFE_F00D, 24'h010000, 8'h02};
    rec_mem[5] = {16'd3, 16'd5, 24'h010100, 8'h04};
    rec_mem[6] = {32'd2, 24'h010200, 8'h06};
    rec_mem[7] = {16'd3, 16'd9, 24'h010300, 8'h08};
    rec_mem[8] = {32'h1111_2222, 24'h010400, 8'h02};
    for (int s = 0; s < 2; s++) begin
      stall = s[0];
      n_exp = 0;
      expect_rec(2, 0, 0, 24'h010000, 32'hCAFE_F00D);
      expect_rec(4, 0, 0, 24'h010100, {16'd3, 16'd5});
      expect_rec(6, 0, 0, 24'h010200, 32'd2);
      expect_rec(8, 0, 0, 24'h010300, {16'd3, 16'd9});
      run(4, 8);
      compare(s ? "R14 stalled window" : "R1 mixed window");
      chk(done_cyc - last_acc == 2, "R13 done timing", done_cyc - last_acc, 2);
    end

    // partial window leaves later records untouched
    stall = 1'b0; n_exp = 0;
    expect_rec(2, 0, 0, 24'h010000, 32'hCAFE_F00D);
    expect_rec(4, 0, 0, 24'h010100, {16'd3, 16'd5});
    run(4, 6);
    compare("R13 partial window");

    // empty windows
    n_exp = 0; run(5, 5); compare("R13 empty window");
    n_exp = 0; run(9, 3); compare("R13 reversed window");

    // zero-length string and zero-length pattern
    rec_mem[10] = {16'd0, 16'd4, 24'h020000, 8'h04};
    rec_mem[11] = {16'd0, 16'd4, 24'h020100, 8'h08};
    n_exp = 0; run(10, 12); compare("R9 zero length");

    // second-variant string copy via folded opcode 0x16, base offset applied
    variant = 1'b1;
    rec_mem[12] = {16'd4, 16'd1, 24'h030000, 8'h16};
    n_exp = 0; expect_rec(8'h16, 1, 0, 24'h030000, {16'd4, 16'd1});
    run(12, 13); compare("R3 string base");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule